// File: doc/BRIEF.md
# Interrupt Router Indirect Register Window

This block is the software-facing register front end of an I/O interrupt router. Software reaches every internal register through two memory-mapped locations. The first is a select register, which holds an index. The second is a data window, which reads or writes whatever register that index names. The indexed space holds four things:
- an identification register,
- a read-only version register,
- an arbitration register that mirrors the identification value,
- a table of 64-bit per-pin redirection entries. Each entry is reached as two 32-bit halves.

The block exports the whole redirection table and the pending-request (IRR) vector to the servicing logic. That logic drives three kinds of strobe into the block: strobes that set IRR bits, strobes that clear IRR bits, and strobes that set the remote-IRR flag of an entry. In return the block issues two one-cycle pulses. One reports a change of a mask bit. The other requests service for a pin. Delivery of the interrupt itself happens elsewhere.

Redirection entry layout (bit positions):

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode |
| 11 | destination mode |
| 13 | polarity |
| 14 | remote IRR |
| 15 | trigger (1 = level) |
| 16 | mask |
| 63:56 | destination ID |

Top module: `irq_route_regs`

## Requirements
- R1: With select = 0x01, a window read returns (PINS-1) in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits 0. With the defaults this value is 0x00170011. Window writes at select 0x01 change nothing.
- R2: With select = 0x00, a window write stores data bits 27:24 as a 4-bit ID, and a window read returns that ID in bits 27:24 with all other bits 0. With select = 0x02, a read returns the same value and writes are ignored.
- R3: A select value S >= 0x10 addresses entry (S-0x10)>>1. S bit 0 = 0 reaches entry bits 31:0, and S bit 0 = 1 reaches bits 63:32. Reads return that half, and the entry is visible on `redir_table` bits [64*pin +: 64].
- R4: A write to the lower half replaces bits 31:0 and leaves the remote-IRR bit (14) at 0. A write to the upper half replaces bits 63:32 only, so bits 31:0 (including remote IRR) are kept.
- R5: A window access whose computed entry index is PINS or more changes nothing, and its read returns 0. Select values 0x03 to 0x0F also read 0.
- R6: Only `bus_addr` bits 7:0 are decoded. Offset 0x00 is the select register, which reads back its full 32-bit value, and offset 0x10 is the window. Other offsets read 0 and ignore writes.
- R7: Writes with `bus_len` = 4 or 8 bytes are accepted and use `bus_wdata` bits 31:0. Writes of any other length are dropped.
- R8: After reset, every entry equals 0x0000_0000_0001_0000 (only the mask set). The select register, the ID and `irr_vec` are 0, and no pulse or read-valid is asserted.
- R9: A lower-half write that changes an entry's mask bit (16) raises `mask_chg_valid` for exactly one cycle, in the cycle after the write. The pulse carries the pin index and the new mask value.
- R10: After any entry write, if the resulting trigger bit is 1 (level) and that pin's IRR bit is set, `svc_valid` pulses for one cycle in the cycle after the write, with `svc_pin` = the pin.
- R11: `rd_valid` and `rd_data` become valid in the cycle after a read request and stay asserted for one cycle. Writes do not raise `rd_valid`.
- R12: `irr_set[i]` sets bit i of `irr_vec` and `irr_clr[i]` clears it (clear wins). `rirr_set[i]` sets remote IRR of entry i unless a lower-half write to it lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_len | input | LEN_W | Access size in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 used |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |
| irr_set | input | PINS | Set strobes for the IRR vector |
| irr_clr | input | PINS | Clear strobes for the IRR vector |
| rirr_set | input | PINS | Set strobes for each entry's remote IRR |
| irr_vec | output | PINS | Current IRR vector |
| redir_table | output | 64*PINS | All redirection entries, pin i at [64*i +: 64] |
| mask_chg_valid | output | 1 | Mask-change pulse |
| mask_chg_pin | output | IDX_W | Pin whose mask changed |
| mask_chg_val | output | 1 | New mask value |
| svc_valid | output | 1 | Service request pulse |
| svc_pin | output | IDX_W | Pin to service |

## Verification
Each entry half is exercised with random data through random pins. Every write is read back both through the window and through the exported table, which separates a half-select or index fault from a storage fault. Directed patterns cover several distinctions:
- a mask-toggling write versus a mask-preserving one, to separate the change pulse from plain write activity;
- level versus edge writes with the IRR bit set, to isolate the service request;
- a set remote-IRR bit overwritten by the upper half and then by the lower half, to show which half clears it.

Dropped sizes, foreign offsets, aliased upper address bits and out-of-range indices are each followed by a read of the state they could have corrupted.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int ENT_W  = 64;
   localparam int HALF_W = 32;
   localparam int F_RIRR = 14;
   localparam int F_TRIG = 15;
   localparam int F_MASK = 16;
   localparam logic [7:0] OFF_SEL = 8'h00;
   localparam logic [7:0] OFF_WIN = 8'h10;
   localparam logic [31:0] SEL_ID   = 32'h0;
   localparam logic [31:0] SEL_VER  = 32'h1;
   localparam logic [31:0] SEL_ARB  = 32'h2;
   localparam logic [31:0] TBL_BASE = 32'h10;

   typedef enum logic [2:0] {RK_NONE, RK_ID, RK_VER, RK_ARB, RK_ENT} regkind_t;

   function automatic logic [ENT_W-1:0] entry_reset();
      return ENT_W'(1) << F_MASK;
   endfunction
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
   import irq_route_pkg::*;
#(
   parameter int PINS  = 24,
   parameter int IDX_W = 5,
   parameter int LEN_W = 4
) (
   input  logic             bus_valid,
   input  logic             bus_write,
   input  logic [7:0]       addr_lo,
   input  logic [LEN_W-1:0] bus_len,
   input  logic [31:0]      sel_q,
   output logic             sel_we,
   output logic             win_we,
   output logic             rd_sel,
   output logic             rd_win,
   output regkind_t         kind,
   output logic [IDX_W-1:0] idx,
   output logic             hi
);
   logic        size_ok;
   logic        at_sel;
   logic        at_win;
   logic [31:0] full_idx;

   assign size_ok = (bus_len == LEN_W'(4)) || (bus_len == LEN_W'(8));
   assign at_sel  = (addr_lo == OFF_SEL);
   assign at_win  = (addr_lo == OFF_WIN);
   assign sel_we  = bus_valid & bus_write & size_ok & at_sel;
   assign win_we  = bus_valid & bus_write & size_ok & at_win;
   assign rd_sel  = bus_valid & ~bus_write & at_sel;
   assign rd_win  = bus_valid & ~bus_write & at_win;

   assign full_idx = (sel_q - TBL_BASE) >> 1;
   assign idx      = full_idx[IDX_W-1:0];
   assign hi       = sel_q[0];

   always_comb begin
      if (sel_q == SEL_ID)       kind = RK_ID;
      else if (sel_q == SEL_VER) kind = RK_VER;
      else if (sel_q == SEL_ARB) kind = RK_ARB;
      else if ((sel_q >= TBL_BASE) && (full_idx < 32'(PINS))) kind = RK_ENT;
      else                       kind = RK_NONE;
   end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
   import irq_route_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] wdata,
   input  logic              rirr_set,
   output logic [ENT_W-1:0]  q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= entry_reset();
      end else begin
         if (rirr_set) q[F_RIRR] <= 1'b1;
         if (we_hi)    q[ENT_W-1:HALF_W] <= wdata;
         if (we_lo) begin
            q[HALF_W-1:0] <= wdata;
            q[F_RIRR]     <= 1'b0;
         end
      end
   end

   AST_LO_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
      we_lo |=> !q[F_RIRR]); // R4
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (we_hi && !we_lo && !rirr_set) |=> $stable(q[HALF_W-1:0])); // R4
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
   import irq_route_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter int         IDX_W   = 5,
   parameter logic [7:0] VERSION = 8'h11
) (
   input  logic                       rd_sel,
   input  logic                       rd_win,
   input  regkind_t                   kind,
   input  logic [IDX_W-1:0]           idx,
   input  logic                       hi,
   input  logic [31:0]                sel_q,
   input  logic [3:0]                 id_q,
   input  logic [PINS-1:0][ENT_W-1:0] tbl,
   output logic [31:0]                rdata_d
);
   localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

   always_comb begin
      rdata_d = '0;
      if (rd_sel) begin
         rdata_d = sel_q;
      end else if (rd_win) begin
         case (kind)
            RK_ID, RK_ARB: rdata_d = {4'h0, id_q, 24'h0};
            RK_VER:        rdata_d = {8'h0, MAX_PIN, 8'h0, VERSION};
            RK_ENT:        rdata_d = hi ? tbl[idx][ENT_W-1:HALF_W] : tbl[idx][HALF_W-1:0];
            default:       rdata_d = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter logic [7:0] VERSION = 8'h11,
   parameter int         ADDR_W  = 12,
   parameter int         LEN_W   = 4,
   localparam int        IDX_W   = $clog2(PINS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [LEN_W-1:0]      bus_len,
   input  logic [63:0]           bus_wdata,
   output logic                  rd_valid,
   output logic [31:0]           rd_data,
   input  logic [PINS-1:0]       irr_set,
   input  logic [PINS-1:0]       irr_clr,
   input  logic [PINS-1:0]       rirr_set,
   output logic [PINS-1:0]       irr_vec,
   output logic [PINS*ENT_W-1:0] redir_table,
   output logic                  mask_chg_valid,
   output logic [IDX_W-1:0]      mask_chg_pin,
   output logic                  mask_chg_val,
   output logic                  svc_valid,
   output logic [IDX_W-1:0]      svc_pin
);
   generate
      if (PINS < 2 || PINS > 256) begin : g_bad_pins
         $error("PINS must lie in 2..256");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (LEN_W < 4) begin : g_bad_len
         $error("LEN_W must be at least 4");
      end
   endgenerate

   logic                       unused_bits;
   logic                       sel_we, win_we, rd_sel, rd_win, hi;
   regkind_t                   kind;
   logic [IDX_W-1:0]           idx;
   logic [31:0]                sel_q, wdata, rdata_d;
   logic [3:0]                 id_q;
   logic [PINS-1:0]            irr_q, we_lo, we_hi;
   logic [PINS-1:0][ENT_W-1:0] tbl;
   logic                       ent_we, old_mask, new_trig;

   assign unused_bits = ^{bus_wdata[63:32], bus_addr};
   assign wdata       = bus_wdata[31:0];

   irq_route_decode #(.PINS(PINS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_dec (
      .bus_valid(bus_valid), .bus_write(bus_write), .addr_lo(bus_addr[7:0]),
      .bus_len(bus_len), .sel_q(sel_q), .sel_we(sel_we), .win_we(win_we),
      .rd_sel(rd_sel), .rd_win(rd_win), .kind(kind), .idx(idx), .hi(hi));

   assign ent_we = win_we && (kind == RK_ENT);

   genvar gi;
   generate
      for (gi = 0; gi < PINS; gi++) begin : g_ent
         assign we_lo[gi] = ent_we && (idx == IDX_W'(gi)) && !hi;
         assign we_hi[gi] = ent_we && (idx == IDX_W'(gi)) && hi;
         irq_route_entry u_ent (
            .clk(clk), .rst_n(rst_n), .we_lo(we_lo[gi]), .we_hi(we_hi[gi]),
            .wdata(wdata), .rirr_set(rirr_set[gi]), .q(tbl[gi]));
         assign redir_table[gi*ENT_W +: ENT_W] = tbl[gi];
      end
   endgenerate

   irq_route_rdmux #(.PINS(PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
      .rd_sel(rd_sel), .rd_win(rd_win), .kind(kind), .idx(idx), .hi(hi),
      .sel_q(sel_q), .id_q(id_q), .tbl(tbl), .rdata_d(rdata_d));

   assign old_mask = tbl[idx][F_MASK];
   assign new_trig = hi ? tbl[idx][F_TRIG] : wdata[F_TRIG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q          <= '0;
         id_q           <= '0;
         irr_q          <= '0;
         rd_valid       <= 1'b0;
         rd_data        <= '0;
         mask_chg_valid <= 1'b0;
         mask_chg_pin   <= '0;
         mask_chg_val   <= 1'b0;
         svc_valid      <= 1'b0;
         svc_pin        <= '0;
      end else begin
         if (sel_we) sel_q <= wdata;
         if (win_we && kind == RK_ID) id_q <= wdata[27:24];
         irr_q          <= (irr_q | irr_set) & ~irr_clr;
         rd_valid       <= bus_valid & ~bus_write;
         rd_data        <= rdata_d;
         mask_chg_valid <= ent_we && !hi && (wdata[F_MASK] != old_mask);
         mask_chg_pin   <= idx;
         mask_chg_val   <= wdata[F_MASK];
         svc_valid      <= ent_we && new_trig && irr_q[idx];
         svc_pin        <= idx;
      end
   end

   assign irr_vec = irr_q;

   AST_MASK_PULSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_valid |-> (tbl[mask_chg_pin][F_MASK] == mask_chg_val)); // R9
   AST_MASK_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_valid |=> !mask_chg_valid || $past(ent_we)); // R9
   AST_SVC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      svc_valid |-> tbl[svc_pin][F_TRIG]); // R10
   AST_ONE_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_lo, we_hi})); // R3
   AST_SIZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_len != LEN_W'(4) && bus_len != LEN_W'(8))
      |=> ($stable(sel_q) && $stable(id_q))); // R7
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
   localparam int PINS = 24;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0]        bus_addr = '0;
   logic [3:0]         bus_len = 4'd4;
   logic [63:0]        bus_wdata = '0;
   logic               rd_valid;
   logic [31:0]        rd_data;
   logic [PINS-1:0]    irr_set = '0, irr_clr = '0, rirr_set = '0;
   logic [PINS-1:0]    irr_vec;
   logic [PINS*64-1:0] tbl;
   logic               mask_chg_valid, mask_chg_val, svc_valid;
   logic [4:0]         mask_chg_pin, svc_pin;

   int                 n_chk = 0, n_err = 0;
   logic [63:0]        m_ent [PINS];
   logic [31:0]        m_sel;
   logic [3:0]         m_id;

   always #4 clk = ~clk;

   irq_route_regs #(.PINS(PINS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .irr_set(irr_set), .irr_clr(irr_clr),
      .rirr_set(rirr_set), .irr_vec(irr_vec), .redir_table(tbl),
      .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
      .mask_chg_val(mask_chg_val), .svc_valid(svc_valid), .svc_pin(svc_pin));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [31:0] s);
      logic [31:0] ix;
      ix = (s - 32'h10) >> 1;
      if (s == 0 || s == 2) return {4'h0, m_id, 24'h0};
      if (s == 1) return 32'h0017_0011;
      if (s >= 32'h10 && ix < PINS) return s[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
      return 32'h0;
   endfunction

   task automatic model_win(input logic [31:0] v);
      logic [31:0] ix;
      ix = (m_sel - 32'h10) >> 1;
      if (m_sel == 0) m_id = v[27:24];
      else if (m_sel >= 32'h10 && ix < PINS) begin
         if (m_sel[0]) m_ent[ix][63:32] = v;
         else begin
            m_ent[ix][31:0] = v;
            m_ent[ix][14]   = 1'b0;
         end
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [3:0] len, input logic [63:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_len = len; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_len = 4'd4;
      @(negedge clk);
      bus_valid = 1'b0;
      chk("R11 rd_valid after read", rd_valid, 1);
      d = rd_data;
   endtask

   task automatic sel_wr(input logic [31:0] v);
      bus_wr(12'h000, 4'd4, {32'h0, v});
      m_sel = v;
   endtask

   task automatic win_wr(input logic [31:0] v);
      bus_wr(12'h010, 4'd4, {32'h0, v});
      model_win(v);
   endtask

   task automatic win_chk(input string req);
      logic [31:0] d;
      bus_rd(12'h010, d);
      chk(req, d, exp_read(m_sel));
   endtask

   task automatic table_chk(input string req);
      for (int i = 0; i < PINS; i++) chk(req, tbl[i*64 +: 64], m_ent[i]);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d, r;
      r = $urandom(32'd2024);
      for (int i = 0; i < PINS; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = 0; m_id = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      chk("R8 rd_valid", rd_valid, 0);
      chk("R8 mask pulse", mask_chg_valid, 0);
      chk("R8 svc pulse", svc_valid, 0);
      chk("R8 irr_vec", irr_vec, 0);
      table_chk("R8 entry reset");
      bus_rd(12'h000, d); chk("R8 select reset", d, 0);
      win_chk("R8 id reset");

      // R1 version, writes ignored
      sel_wr(32'h1);
      win_chk("R1 version read");
      win_wr(32'hFFFF_FFFF);
      win_chk("R1 version write ignored");

      // R2 ID and arbitration
      sel_wr(32'h0);
      win_wr(32'hA500_0000);
      win_chk("R2 id write/read");
      chk("R2 id value", exp_read(0), 32'h0500_0000);
      sel_wr(32'h2);
      win_chk("R2 arb mirrors id");
      win_wr(32'h0F00_0000);
      sel_wr(32'h0);
      win_chk("R2 arb write ignored");

      // R6 address decode
      bus_rd(12'h020, d); chk("R6 foreign offset reads 0", d, 0);
      bus_wr(12'h020, 4'd4, 64'h55);
      bus_rd(12'h000, d); chk("R6 foreign write dropped", d, 0);
      bus_wr(12'h300, 4'd4, 64'h16); m_sel = 32'h16;
      bus_rd(12'h700, d); chk("R6 upper address bits ignored", d, 32'h16);
      bus_wr(12'h000, 4'd4, 64'h0); m_sel = 0;
      @(negedge clk);
      chk("R11 no rd_valid after write", rd_valid, 0);

      // R7 sizes
      bus_wr(12'h000, 4'd2, 64'h99);
      bus_wr(12'h000, 4'd1, 64'h98);
      bus_rd(12'h000, d); chk("R7 short writes dropped", d, 0);
      bus_wr(12'h000, 4'd8, 64'hDEAD_BEEF_0000_0013); m_sel = 32'h13;
      bus_rd(12'h000, d); chk("R7 8-byte write low half", d, 32'h13);

      // R3 R4 R9: pin 3 lower half, mask 1 -> 0, level
      sel_wr(32'h16);
      win_wr(32'h0000_A031);
      chk("R9 mask pulse", mask_chg_valid, 1);
      chk("R9 mask pin", mask_chg_pin, 3);
      chk("R9 mask value", mask_chg_val, 0);
      chk("R10 no svc without irr", svc_valid, 0);
      @(negedge clk);
      chk("R9 pulse one cycle", mask_chg_valid, 0);
      win_wr(32'h0000_A032);
      chk("R9 no pulse when mask unchanged", mask_chg_valid, 0);
      win_chk("R3 pin3 low half");
      @(negedge clk); rirr_set[3] = 1'b1;
      @(negedge clk); rirr_set[3] = 1'b0; m_ent[3][14] = 1'b1;
      win_chk("R12 remote irr set");
      sel_wr(32'h17);
      win_wr(32'hFF00_0000);
      win_chk("R3 pin3 high half");
      chk("R4 high write keeps remote irr", tbl[3*64 + 14], 1);
      sel_wr(32'h16);
      win_wr(32'h0000_A032);
      chk("R4 low write clears remote irr", tbl[3*64 + 14], 0);
      table_chk("R3 table after pin3");

      // R10 R12 service request
      @(negedge clk); irr_set[5] = 1'b1;
      @(negedge clk); irr_set[5] = 1'b0;
      chk("R12 irr set", irr_vec, 24'h000020);
      sel_wr(32'h1A);
      win_wr(32'h0000_8040);
      chk("R10 svc on level write", svc_valid, 1);
      chk("R10 svc pin", svc_pin, 5);
      @(negedge clk);
      chk("R10 svc one cycle", svc_valid, 0);
      sel_wr(32'h1B);
      win_wr(32'h0100_0000);
      chk("R10 svc on upper write of level entry", svc_valid, 1);
      sel_wr(32'h1A);
      win_wr(32'h0000_0040);
      chk("R10 no svc on edge entry", svc_valid, 0);
      @(negedge clk); irr_set[5] = 1'b1; irr_clr[5] = 1'b1;
      @(negedge clk); irr_set[5] = 1'b0; irr_clr[5] = 1'b0;
      chk("R12 clear wins", irr_vec, 0);

      // R5 out of range
      sel_wr(32'h10 + 2 * PINS);
      win_wr(32'h1234_5678);
      win_chk("R5 out-of-range read 0");
      table_chk("R5 out-of-range write no effect");
      sel_wr(32'h05);
      win_chk("R5 reserved select reads 0");

      // R3 R4 random
      for (int k = 0; k < 300; k++) begin
         int pin;
         logic h;
         logic [31:0] v;
         pin = int'($urandom % PINS);
         h   = 1'($urandom);
         v   = $urandom;
         sel_wr(32'h10 + 32'(2 * pin) + 32'(h));
         win_wr(v);
         win_chk("R3 random readback");
         chk("R4 random table", tbl[pin*64 +: 64], m_ent[pin]);
      end
      table_chk("R3 final table");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule